// File: doc/BRIEF.md
# Serial Status-Command Slave with Pause and Write Lock

This block is the command front end of a serial memory slave. It samples chip select, serial clock and serial data in the chip's own clock domain, assembles 8-bit opcodes, and serves three status commands: set the write-enable latch, read the status byte, and write the status byte. The serial output has a separate drive-enable so the pad can float when the slave is not talking. The memory array and any use of the protection bits for address decoding sit elsewhere and only see the status byte.

A pause input lets the master suspend a transaction midway. While paused, the slave ignores clock and data, floats its output, and keeps its place in the bit stream, so the transfer resumes where it stopped. Status writes are guarded twice: the write-enable latch must be set, and a lock bit in the status byte, qualified by a write-protect pin, can refuse the write outright.

Top module: `spi_status_slave`

## Requirements
- R1: After reset the status byte is 0x00, so_en is low and hold_err is low.
- R2: Opcodes are 8 bits, MSB first, with si sampled on the sck rising edge. Opcode 0x06, followed by cs_n rising after exactly 8 bits, sets the write-enable latch (status bit 1).
- R3: After opcode 0x05, so presents the status byte MSB first, updated on sck falling edges, repeating every 8 bits; so_en is high only in this output phase while cs_n is low, and low otherwise.
- R4: Opcode 0x01 followed by exactly 8 data bits writes the status byte when cs_n rises; only bits 7, 5, 3 and 2 take the written value, bits 0, 1, 4 and 6 become 0. With fewer or more than 8 data bits nothing changes.
- R5: A status write is applied only if the write-enable latch was set; any status write with exactly 8 data bits clears the latch, whether applied or not.
- R6: A status write is refused when wp_n is low and status bit 7 (lock) is 1; it is applied when wp_n is low and bit 7 is 0, and whenever wp_n is high.
- R7: With cs_n low, hold_n falling while sck is low starts a pause in which sck and si are ignored and the bit position is kept; hold_n rising while sck is low ends it and the transaction continues.
- R8: so_en is low throughout a pause.
- R9: cs_n rising during a pause abandons the transaction: no command takes effect, the pause ends, and the next cs_n low period starts a fresh opcode.
- R10: A hold_n edge while sck is high and cs_n is low neither starts nor ends a pause and sets hold_err, which stays set until reset.
- R11: hold_n edges while cs_n is high have no effect and do not set hold_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to sample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Drive enable for so; low means high impedance |
| status | output | 8 | Current status byte |
| hold_err | output | 1 | Sticky flag: hold_n moved while sck was high |

## Verification
The checks assume the serial pins are already synchronous to clk, that every sck level lasts at least one clk cycle, and that hold_n and sck never change in the same cycle, so edge detection from one registered copy is exact. The bench drives every pin on the falling clk edge with sck half-periods of two cycles and moves hold_n only while sck is steady, including the deliberate high-sck glitch. Under these assumptions the properties tie status changes to a cs_n rise, to a set write-enable latch and to an unlocked or unprotected state, and keep the output floating during a pause.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam int OP_W   = 8;
    localparam int STAT_W = 8;

    localparam logic [OP_W-1:0] OPC_WREN = 8'h06;
    localparam logic [OP_W-1:0] OPC_RDSR = 8'h05;
    localparam logic [OP_W-1:0] OPC_WRSR = 8'h01;

    localparam int B_WEL  = 1;
    localparam int B_LOCK = 7;

    // bits 7 (lock), 5, 3, 2 are writable; 0, 1, 4, 6 are cleared by a write
    localparam logic [STAT_W-1:0] WR_MASK = 8'hAC;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_WEN,
        PH_RD,
        PH_WR,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic sck;
        logic hold_n;
        logic cs_n;
    } pins_t;

    localparam pins_t IDLE_PINS = '{sck: 1'b0, hold_n: 1'b1, cs_n: 1'b1};

    function automatic phase_e op_phase(input logic [OP_W-1:0] op);
        case (op)
            OPC_WREN: return PH_WEN;
            OPC_RDSR: return PH_RD;
            OPC_WRSR: return PH_WR;
            default:  return PH_SKIP;
        endcase
    endfunction

    function automatic logic wrsr_ok(input logic wel, input logic wp_n,
                                     input logic lock);
        return wel && (wp_n || !lock);
    endfunction

endpackage

// File: rtl/spi_pin_edges.sv
module spi_pin_edges #(
    parameter int             W       = 3,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= pins_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign rise_o[g] =  pins_i[g] & ~prev_q[g];
        assign fall_o[g] = ~pins_i[g] &  prev_q[g];
    end
endmodule

// File: rtl/spi_hold_ctl.sv
module spi_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic csn_i,
    input  logic sck_i,
    input  logic hold_rise_i,
    input  logic hold_fall_i,
    output logic paused_o,
    output logic err_o
);
    logic paused_q;
    logic err_q;
    logic hold_edge;

    assign hold_edge = hold_rise_i | hold_fall_i;

    always_ff @(posedge clk) begin
        if (rst || csn_i) begin
            paused_q <= 1'b0;
        end else if (!sck_i) begin
            if (hold_fall_i)      paused_q <= 1'b1;
            else if (hold_rise_i) paused_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                            err_q <= 1'b0;
        else if (!csn_i && sck_i && hold_edge) err_q <= 1'b1;
    end

    assign paused_o = paused_q;
    assign err_o    = err_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_stat_pkg::*;
#(
    parameter int OPW = OP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           csn_i,
    input  logic           cs_rise_i,
    input  logic           cs_fall_i,
    input  logic           sck_rise_i,
    input  logic           sck_fall_i,
    input  logic           paused_i,
    input  logic           si_i,
    input  logic [OPW-1:0] stat_i,
    output logic           so_o,
    output logic           so_en_o,
    output logic           wren_go_o,
    output logic           wrsr_go_o,
    output logic [OPW-1:0] wdata_o
);
    localparam int CNT_W = $clog2(OPW + 2);
    localparam int IDX_W = $clog2(OPW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OPW - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OPW);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(OPW + 1);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(OPW - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [OPW-1:0]   sh_q;
    logic [IDX_W-1:0] idx_q;
    logic             so_q;
    logic             active;
    logic [OPW-1:0]   sh_nx;

    assign active = !csn_i && !paused_i;
    assign sh_nx  = {sh_q[OPW-2:0], si_i};

    always_ff @(posedge clk) begin
        if (rst || csn_i || cs_fall_i) begin
            ph_q  <= PH_CMD;
            cnt_q <= '0;
            sh_q  <= '0;
            idx_q <= '0;
            so_q  <= 1'b0;
        end else if (active) begin
            if (sck_rise_i) begin
                sh_q <= sh_nx;
                case (ph_q)
                    PH_CMD: begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q <= '0;
                            ph_q  <= op_phase(sh_nx);
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_WEN:  ph_q <= PH_SKIP;
                    PH_WR:   if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                    default: ;
                endcase
            end
            if (sck_fall_i && ph_q == PH_RD) begin
                so_q  <= stat_i[TOP_IDX - idx_q];
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign so_o      = so_q;
    assign so_en_o   = active && (ph_q == PH_RD);
    assign wren_go_o = cs_rise_i && !paused_i && (ph_q == PH_WEN);
    assign wrsr_go_o = cs_rise_i && !paused_i && (ph_q == PH_WR) && (cnt_q == CNT_FULL);
    assign wdata_o   = sh_q;
endmodule

// File: rtl/spi_stat_reg.sv
module spi_stat_reg
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_go_i,
    input  logic              wrsr_go_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              wp_n_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (wrsr_go_i) begin
            if (wrsr_ok(stat_q[B_WEL], wp_n_i, stat_q[B_LOCK]))
                stat_q <= wdata_i & WR_MASK;
            else
                stat_q[B_WEL] <= 1'b0;
        end else if (wren_go_i) begin
            stat_q[B_WEL] <= 1'b1;
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave
    import spi_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    output logic              so,
    output logic              so_en,
    output logic [STAT_W-1:0] status,
    output logic              hold_err
);
    pins_t             pins_now;
    pins_t             pin_rise;
    pins_t             pin_fall;
    logic              paused;
    logic              wren_go;
    logic              wrsr_go;
    logic [STAT_W-1:0] wdata;
    logic [STAT_W-1:0] stat_w;

    assign pins_now = '{sck: sck, hold_n: hold_n, cs_n: cs_n};

    spi_pin_edges #(
        .W       ($bits(pins_t)),
        .RST_VAL (IDLE_PINS)
    ) u_edges (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_now),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    spi_hold_ctl u_hold (
        .clk         (clk),
        .rst         (rst),
        .csn_i       (cs_n),
        .sck_i       (sck),
        .hold_rise_i (pin_rise.hold_n),
        .hold_fall_i (pin_fall.hold_n),
        .paused_o    (paused),
        .err_o       (hold_err)
    );

    spi_cmd_engine #(
        .OPW (STAT_W)
    ) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .csn_i      (cs_n),
        .cs_rise_i  (pin_rise.cs_n),
        .cs_fall_i  (pin_fall.cs_n),
        .sck_rise_i (pin_rise.sck),
        .sck_fall_i (pin_fall.sck),
        .paused_i   (paused),
        .si_i       (si),
        .stat_i     (stat_w),
        .so_o       (so),
        .so_en_o    (so_en),
        .wren_go_o  (wren_go),
        .wrsr_go_o  (wrsr_go),
        .wdata_o    (wdata)
    );

    spi_stat_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .wren_go_i (wren_go),
        .wrsr_go_i (wrsr_go),
        .wdata_i   (wdata),
        .wp_n_i    (wp_n),
        .stat_o    (stat_w)
    );

    assign status = stat_w;
endmodule

// File: rtl/spi_status_slave_chk.sv
module spi_status_slave_chk
    import spi_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wp_n,
    input logic              so_en,
    input logic [STAT_W-1:0] status,
    input logic              hold_err,
    input logic              paused
);
    // R8: output floats while paused
    a_r8_quiet_in_pause: assert property (@(posedge clk) disable iff (rst)
        paused |-> !so_en);

    // R3: output is driven only while selected
    a_r3_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
        so_en |-> !cs_n);

    // R10: protocol error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        hold_err |=> hold_err);

    // R4: the status byte only changes on a chip-select rise
    a_r4_change_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |-> $past(cs_n) && cs_n);

    // R5: written bits move only if the write-enable latch was set
    a_r5_needs_wel: assert property (@(posedge clk) disable iff (rst)
        (status[7:2] != $past(status[7:2])) |-> $past(status[B_WEL]));

    // R6: a locked byte with protect pin low never changes its written bits
    a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
        ((status & WR_MASK) != $past(status & WR_MASK)) |->
            ($past(wp_n) || !$past(status[B_LOCK])));

    // R9: a deselect always ends the pause
    a_r9_pause_cleared: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !paused);
endmodule

bind spi_status_slave spi_status_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .wp_n     (wp_n),
    .so_en    (so_en),
    .status   (status),
    .hold_err (hold_err),
    .paused   (paused)
);

// File: tb/spi_status_slave_tb.sv
module spi_status_slave_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic       wp_n = 1'b1;
    logic       so;
    logic       so_en;
    logic [7:0] status;
    logic       hold_err;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] cap = 8'h00;
    int         ncap = 0;

    always #10 clk = ~clk;

    spi_status_slave u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en),
        .status(status), .hold_err(hold_err)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: collect bits the master would sample, compare at deselect
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (ncap >= 8) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R3: actual %h expected <none queued>", cap);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cap !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", t, cap, e);
                    end
                end
            end
            ncap = 0;
        end else if (so_en) begin
            cap = {cap[6:0], so};
            ncap++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            si = v[i];
            tick(2);
            sck = 1'b1;
            tick(2);
            sck = 1'b0;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic desel();
        tick(2);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic do_wren();
        sel(); send_bits(16'h06, 8); desel();
    endtask

    task automatic do_wrsr(input logic [15:0] d, input int nbits);
        sel(); send_bits(16'h01, 8); send_bits(d, nbits); desel();
    endtask

    task automatic read_stat(input logic [7:0] exp, input string tag, input int nbits);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        sel(); send_bits(16'h05, 8); send_bits(16'h0000, nbits); desel();
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        check(status, 8'h00, "R1 status");
        check(so_en, 1'b0, "R1 so_en");
        check(hold_err, 1'b0, "R1 hold_err");

        read_stat(8'h00, "R3 read zero", 8);
        check(so_en, 1'b0, "R3 so_en after deselect");

        do_wrsr(16'hAA, 8);
        check(status, 8'h00, "R5 write without latch");

        do_wren();
        check(status, 8'h02, "R2 latch set");
        read_stat(8'h02, "R3 read latch", 8);

        wp_n = 1'b0;
        do_wrsr(16'hFF, 8);
        check(status, 8'hAC, "R4 masked write, R6 unlocked with pin low");
        read_stat(8'hAC, "R3 repeating read", 16);

        do_wren();
        check(status, 8'hAE, "R2 latch set again");
        do_wrsr(16'h00, 8);
        check(status, 8'hAC, "R6 lock refuses, R5 latch cleared");

        wp_n = 1'b1;
        do_wren();
        do_wrsr(16'h28, 8);
        check(status, 8'h28, "R6 pin high overrides lock");

        do_wren();
        do_wrsr(16'h00, 7);
        check(status, 8'h2A, "R4 short write ignored");
        do_wrsr(16'h000, 9);
        check(status, 8'h2A, "R4 long write ignored");

        // R7: pause in the middle of the data byte 0x84
        sel();
        send_bits(16'h01, 8);
        send_bits(16'h8, 4);
        hold_n = 1'b0;
        tick(3);
        si = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(2); sck = 1'b1; tick(2); sck = 1'b0;
        end
        tick(2);
        hold_n = 1'b1;
        tick(2);
        send_bits(16'h4, 4);
        desel();
        check(status, 8'h84, "R7 resumed write");

        // R8: output floats during a pause in a read
        exp_q.push_back(8'h84);
        tag_q.push_back("R7 resumed read");
        sel();
        send_bits(16'h05, 8);
        check(so_en, 1'b1, "R3 drive in read phase");
        hold_n = 1'b0;
        tick(3);
        check(so_en, 1'b0, "R8 float while paused");
        hold_n = 1'b1;
        tick(3);
        check(so_en, 1'b1, "R7 drive after resume");
        send_bits(16'h00, 8);
        desel();

        // R9: deselect during pause abandons a complete write
        do_wren();
        check(status, 8'h86, "R2 latch before abandon");
        sel();
        send_bits(16'h01, 8);
        send_bits(16'h00, 8);
        hold_n = 1'b0;
        tick(3);
        cs_n = 1'b1;
        tick(4);
        check(status, 8'h86, "R9 abandoned write");
        hold_n = 1'b1;
        tick(3);
        check(hold_err, 1'b0, "R11 edge while deselected");
        do_wrsr(16'h00, 8);
        check(status, 8'h00, "R9 fresh command after abandon");

        // R11: hold low while deselected does not pause the next command
        hold_n = 1'b0;
        tick(3);
        do_wren();
        check(status, 8'h02, "R11 no pause from idle hold edge");
        hold_n = 1'b1;
        tick(3);
        check(hold_err, 1'b0, "R11 no error while deselected");

        // R10: hold edges with sck high are ignored and flagged
        sel();
        send_bits(16'h01, 8);
        send_bits(16'h0, 3);
        si = 1'b0;
        tick(2);
        sck = 1'b1;
        tick(2);
        hold_n = 1'b0;
        tick(2);
        sck = 1'b0;
        tick(2);
        check(hold_err, 1'b1, "R10 flag set");
        send_bits(16'h0, 3);
        si = 1'b0;
        tick(2);
        sck = 1'b1;
        tick(2);
        hold_n = 1'b1;
        tick(2);
        sck = 1'b0;
        desel();
        check(status, 8'h00, "R10 no pause, all 8 bits counted");
        read_stat(8'h00, "R10 read after glitch", 8);
        check(hold_err, 1'b1, "R10 flag sticky");

        check(exp_q.size(), 0, "R3 all queued reads seen");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule